// File: doc/BRIEF.md
# Pipelined Burst SRAM Controller with Embedded Array

This block holds the synchronous front end of a pipelined burst SRAM and a small storage array behind it. It samples its control pins on every rising clock edge. Two active-low address strobes can open a cycle: a host-side strobe that always reads, and a controller-side strobe that reads or writes. Three chip selects decide whether an opened cycle addresses the array or deselects it. After an address is taken, an active-low advance pin steps a two-bit beat counter through a four-word block. The order of the beats is linear or interleaved, and a static mode pin picks it.

Writes are byte-laned. A global write pin stores the whole word. Otherwise a byte-write gate, together with one active-low enable per lane, picks which lanes take the input data. Read data passes through one output register, so it appears after the clock edge that accepted the access. An output-enable flag drops after any write, deselect or idle cycle, so the bus turns around within one clock.

Data moves with no handshake in either direction. Write data must be valid on the edge where the write is sampled. Read data is valid for exactly the cycle in which `dout_en` is high, and the array cannot be stalled. There is no ready and no back-pressure.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset `dout_en` is low and no burst is open: an advance pulse with no strobe produces no read.
- R2: A host strobe (`adsp_n` low) with `cs_n` low, `cs_hi` high and `cs_lo_n` low reads the word at `addr`. This holds whatever the write enables and `adsc_n` are. The word appears on `dout` with `dout_en` high after that edge.
- R3: While `cs_n` is high, `adsp_n` is ignored. With `adsc_n` high, an open burst keeps its position and is not replaced.
- R4: A cycle opened with `cs_hi` low or `cs_lo_n` high deselects. `dout_en` is low next cycle, and later advances produce no reads until a new cycle opens.
- R5: A controller strobe (`adsc_n` low) with all selects active loads `addr`. It writes if `gw_n` is low, or if `bwe_n` is low with at least one `bw_n` bit low. Otherwise it reads.
- R6: `adsc_n` low while `cs_n` is high deselects, ending any open burst.
- R7: With `mode` low, beat k of a burst started at low bits s addresses low bits (s+k) mod 4. The upper address bits are kept.
- R8: With `mode` high, beat k addresses low bits s XOR k.
- R9: With no strobe and a burst open, `adv_n` low steps the beat counter by one. `adv_n` high holds it, and the same word is accessed again.
- R10: `gw_n` low writes all four byte lanes. Otherwise, with `bwe_n` low, lane i (bits 8i+7..8i) is written only when `bw_n[i]` is low. This applies both to the opening write cycle and to continued beats.
- R11: Read data appears one clock after its access cycle. `dout_en` is low in the cycle after a write.
- R12: Either strobe opening a cycle abandons a burst in progress and restarts the beat count at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adsp_n | input | 1 | Host address strobe, active low, read only |
| adsc_n | input | 1 | Controller address strobe, active low, read or write |
| cs_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Secondary select, active high |
| cs_lo_n | input | 1 | Secondary select, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| mode | input | 1 | Burst order: low linear, high interleaved |
| addr | input | 6 | Word address |
| din | input | 32 | Write data, four byte lanes |
| dout | output | 32 | Registered read data |
| dout_en | output | 1 | Output drive enable, high when `dout` holds read data |

## Verification
The assertions rely on `mode` staying constant while a burst is open. They also rely on the select inputs being driven to defined levels on every edge after reset. The stimulus changes `mode` only in idle cycles or just before a strobe opens a new cycle, and it always drives every control pin at the falling edge. The sweeps cover every starting low address in both burst orders, all sixteen lane masks, both kinds of deselect, and strobes that interrupt a burst partway through.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BEATS_W = 2;

  typedef logic [BEATS_W-1:0] beat_t;

  // Low address bits for beat k of a burst that started at s.
  function automatic beat_t beat_low(input logic interleave, input beat_t s, input beat_t k);
    beat_t r;
    if (interleave) r = s ^ k;
    else            r = s + k;
    return r;
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic             load,
  output logic             advance,
  output logic             rd_en,
  output logic             wr_en,
  output logic [LANES-1:0] wr_mask,
  output logic             active_q
);
  logic host_go, ctl_go, strobe, sel_ok, opened, desel, cont, wr_req;

  always_comb begin
    host_go = !adsp_n && !cs_n;          // host strobe needs primary select
    ctl_go  = !adsc_n && !host_go;       // host strobe has priority
    strobe  = host_go || ctl_go;
    sel_ok  = !cs_n && cs_hi && !cs_lo_n;
    opened  = strobe && sel_ok;
    desel   = strobe && !sel_ok;
    cont    = !strobe && active_q;

    if (!gw_n)       wr_mask = '1;
    else if (!bwe_n) wr_mask = ~bw_n;
    else             wr_mask = '0;
    wr_req  = |wr_mask;

    load    = opened;
    advance = cont && !adv_n;
    wr_en   = ((opened && ctl_go) || cont) && wr_req;
    rd_en   = (opened && host_go) || (((opened && ctl_go) || cont) && !wr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active_q <= 1'b0;
    else if (opened) active_q <= 1'b1;
    else if (desel)  active_q <= 1'b0;
  end
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr,
  output beat_t             cnt_q
);
  logic [ADDR_W-1:0] base_q, base_d;
  beat_t             cnt_d;

  always_comb begin
    base_d = load ? addr_in : base_q;
    if (load)         cnt_d = '0;
    else if (advance) cnt_d = cnt_q + beat_t'(1);
    else              cnt_d = cnt_q;
    acc_addr = {base_d[ADDR_W-1:BEATS_W], beat_low(mode, base_d[BEATS_W-1:0], cnt_d)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout_q,
  output logic                    dout_en_q
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) mem[addr][g*LANE_W +: LANE_W] <= din[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q    <= '0;
      dout_en_q <= 1'b0;
    end else begin
      dout_en_q <= rd_en;
      if (rd_en) dout_q <= mem[addr];
    end
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    cs_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  logic              load, advance, rd_en, wr_en, active_q;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] acc_addr;
  beat_t             cnt_q;

  sbs_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .cs_n(cs_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .load(load), .advance(advance), .rd_en(rd_en), .wr_en(wr_en),
    .wr_mask(wr_mask), .active_q(active_q)
  );

  sbs_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .mode(mode),
    .addr_in(addr), .acc_addr(acc_addr), .cnt_q(cnt_q)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_mask(wr_mask),
    .addr(acc_addr), .din(din), .dout_q(dout), .dout_en_q(dout_en)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       adsp_n,
  input logic       adsc_n,
  input logic       cs_n,
  input logic       cs_hi,
  input logic       cs_lo_n,
  input logic       adv_n,
  input logic       gw_n,
  input logic       dout_en,
  input logic       active,
  input logic [1:0] cnt
);
  // R2: host read with full select always drives data next cycle
  p_host_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !cs_n && cs_hi && !cs_lo_n) |=> dout_en);

  // R3: host strobe under high primary select leaves an open burst in place
  p_host_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && adsc_n && adv_n && active) |=> (active && $stable(cnt)));

  // R4: secondary select off at open deselects
  p_sec_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !cs_n && !(cs_hi && !cs_lo_n)) |=> (!dout_en && !active));

  // R6: controller strobe with primary select high deselects
  p_ctl_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && cs_n) |=> (!dout_en && !active));

  // R9: counter holds without advance
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && adsc_n && adv_n) |=> $stable(cnt));

  // R9: counter steps on advance
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && adsc_n && !adv_n && active) |=> (cnt == 2'($past(cnt) + 2'd1)));

  // R11: a global write opened by the controller strobe leaves outputs off
  p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && !adsc_n && !cs_n && cs_hi && !cs_lo_n && !gw_n) |=> !dout_en);

  // R12: any opened cycle restarts the beat count
  p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (((!adsp_n && !cs_n) || !adsc_n) && !cs_n && cs_hi && !cs_lo_n) |=> (cnt == 2'd0));
endmodule

bind sync_burst_sram sbs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .cs_n(cs_n),
  .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n), .gw_n(gw_n),
  .dout_en(dout_en), .active(active_q), .cnt(cnt_q)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adsp_n, adsc_n, cs_n, cs_hi, cs_lo_n, adv_n, gw_n, bwe_n, mode;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [31:0] din;
  logic [31:0] dout;
  logic        dout_en;

  logic [31:0] mem_m [64];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sync_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .cs_n(cs_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .mode(mode), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; cs_n = 0; cs_hi = 1; cs_lo_n = 0; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic logic [31:0] pat(input int a);
    return {8'(a), 8'(a ^ 8'h5A), 8'(~a), 8'(a + 3)};
  endfunction

  function automatic int beat_addr(input int start, input int k, input logic m);
    int lo;
    lo = m ? ((start % 4) ^ k) : (((start % 4) + k) % 4);
    return (start / 4) * 4 + lo;
  endfunction

  task automatic expect_read(input string tag, input int a);
    chk({tag, " dout_en"}, {31'd0, dout_en}, 32'd1);
    chk({tag, " data"}, dout, mem_m[a]);
  endtask

  task automatic host_read(input int a);
    adsp_n = 0; addr = 6'(a);
    tick();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(); mode = 0; addr = 0; din = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 dout_en in reset", {31'd0, dout_en}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    adv_n = 0; tick();
    chk("R1 no burst after reset", {31'd0, dout_en}, 32'd0);

    // fill array with global writes (R5, R10, R11)
    for (int a = 0; a < 64; a++) begin
      adsc_n = 0; gw_n = 0; addr = 6'(a); din = pat(a);
      mem_m[a] = pat(a);
      tick();
      chk("R11 no output after write", {31'd0, dout_en}, 32'd0);
    end

    // burst order sweep: R2, R7, R8, R9
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 3; b++) begin
        for (int s = 0; s < 4; s++) begin
          int st;
          st = (b == 0 ? 0 : (b == 1 ? 20 : 44)) + s;
          mode = logic'(m);
          // host strobe with write enables and controller strobe active: still a read
          adsp_n = 0; adsc_n = 0; gw_n = 0; bwe_n = 0; bw_n = 0;
          addr = 6'(st); din = 32'hDEAD_BEEF;
          tick();
          expect_read("R2 host read", st);
          for (int k = 1; k < 4; k++) begin
            adv_n = 0; tick();
            expect_read(m ? "R8 interleaved beat" : "R7 linear beat", beat_addr(st, k, logic'(m)));
          end
        end
      end
    end

    // hold and ignored host strobe: R9, R3
    mode = 0;
    host_read(8);
    adv_n = 0; tick();
    expect_read("R9 advance", 9);
    tick();
    expect_read("R9 hold repeats word", 9);
    cs_n = 1; adsp_n = 0; addr = 6'd33; tick();
    expect_read("R3 host strobe ignored", 9);
    adv_n = 0; tick();
    expect_read("R3 burst continues", 10);

    // byte lanes: R10, R5
    for (int msk = 0; msk < 16; msk++) begin
      logic [31:0] d;
      d = 32'h1111_1111 * (msk + 1) ^ 32'hA5C3_0F96;
      adsc_n = 0; bwe_n = 0; bw_n = ~4'(msk); addr = 6'd30; din = d;
      for (int i = 0; i < 4; i++)
        if (msk[i]) mem_m[30][8*i +: 8] = d[8*i +: 8];
      tick();
      if (msk == 0) expect_read("R5 no lanes selected reads", 30);
      host_read(30);
      expect_read("R10 lane mask read back", 30);
    end
    // bw_n low but bwe_n high: read, no write (R5)
    adsc_n = 0; bwe_n = 1; bw_n = 4'h0; addr = 6'd30; din = 32'hFFFF_FFFF; tick();
    expect_read("R5 controller read", 30);
    host_read(30);
    expect_read("R5 array unchanged", 30);

    // continued burst write: R10
    mode = 0;
    adsc_n = 0; gw_n = 0; addr = 6'd40; din = 32'hC0DE_0040; mem_m[40] = din; tick();
    adv_n = 0; gw_n = 0; din = 32'hC0DE_0041; mem_m[41] = din; tick();
    adv_n = 0; bwe_n = 0; bw_n = 4'b1100; din = 32'h7777_7777;
    mem_m[42][15:0] = 16'h7777; tick();
    chk("R11 quiet after continued write", {31'd0, dout_en}, 32'd0);
    host_read(40);
    expect_read("R10 burst write beat0", 40);
    for (int k = 1; k < 4; k++) begin
      adv_n = 0; tick();
      expect_read("R10 burst write beat", 40 + k);
    end

    // deselect: R4, R6
    adsp_n = 0; cs_hi = 0; addr = 6'd5; tick();
    chk("R4 secondary high-select off", {31'd0, dout_en}, 32'd0);
    adv_n = 0; tick();
    chk("R4 no burst after deselect", {31'd0, dout_en}, 32'd0);
    adsc_n = 0; cs_lo_n = 1; addr = 6'd5; tick();
    chk("R4 secondary low-select off", {31'd0, dout_en}, 32'd0);
    host_read(12);
    expect_read("R6 burst open", 12);
    adsc_n = 0; cs_n = 1; tick();
    chk("R6 controller deselect", {31'd0, dout_en}, 32'd0);
    adv_n = 0; tick();
    chk("R6 burst ended", {31'd0, dout_en}, 32'd0);

    // interrupting strobes: R12
    mode = 1;
    host_read(6);
    adv_n = 0; tick();
    expect_read("R12 before interrupt", 7);
    adsc_n = 0; addr = 6'd51; tick();
    expect_read("R12 controller interrupt", 51);
    adv_n = 0; tick();
    expect_read("R12 restarted count", 50);
    host_read(17);
    expect_read("R12 host interrupt", 17);
    adv_n = 0; tick();
    expect_read("R12 host restarted", 16);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule